// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This block is the front of a five-stage pipelined core for a small 64-bit instruction set with variable-length encodings. It holds a byte-addressed instruction store and, for the fetch address it is handed each cycle, reads a window of ten consecutive bytes. From that window it splits out the operation code and function code, the two register specifiers and any 64-bit immediate. It also works out how long the instruction is, so it can form the sequential next address.

It also guesses the next fetch address and reports a status for the fetched instruction. The guess is the immediate target for jumps and calls, and the sequential address for everything else. The status is one of normal, halt, bad instruction or bad address, and it also drives three single-bit flags. Choosing between the guess and a corrected address is left to the pipeline's PC selection logic outside this block.

The read path is purely combinational from `pc` to the outputs. The only clocked element is a byte-wide write port, which is used to load the program before the core runs.

Top module: `fetch_unit`

## Requirements
- R1: `f_icode` is bits 7:4 and `f_ifun` is bits 3:0 of the byte at `pc`, unless R8 applies.
- R2: Instruction length comes from the operation code. It is 1 byte for codes 0x0, 0x1, 0x9 and any invalid code, 2 bytes for 0x2, 0x6, 0xA and 0xB, 9 bytes for 0x7 and 0x8, and 10 bytes for 0x3, 0x4 and 0x5. `f_valP` equals `pc` plus that length, wrapping at 64 bits.
- R3: For codes 0x2 to 0x6, 0xA and 0xB, `f_rA` is bits 7:4 and `f_rB` is bits 3:0 of the byte at `pc+1`. For all other codes both are 0xF.
- R4: `f_valC` is assembled least-significant byte first. For codes 0x3 to 0x5 it comes from bytes `pc+2`..`pc+9`, and for 0x7 and 0x8 it comes from bytes `pc+1`..`pc+8`. For all other codes it is zero.
- R5: `f_pred` equals `f_valC` for codes 0x7 and 0x8 and equals `f_valP` otherwise.
- R6: An operation code above 0xB gives `f_stat` = 4 and a low `f_inst_ok`.
- R7: Code 0x0 gives `f_stat` = 2 and a high `f_halt`.
- R8: If `pc` ≥ 2048, or if the last byte of the instruction (by R2 length) lies above address 2047, then `f_stat` = 3 and `f_adr_err` is high. The fields are then replaced by a 1-byte no-op: icode 1, ifun 0, rA and rB 0xF, valC 0, and `f_valP` = `f_pred` = `pc`+1. This status takes priority over those of R6 and R7.
- R9: In every other case `f_stat` = 1. `f_inst_ok` is high exactly for status 1 or 2.
- R10: A byte on `wr_data` is stored at `wr_addr` on a rising clock edge while `wr_en` is high. The write is ignored while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Active-low reset; blocks writes |
| wr_en | input | 1 | Program-load write enable |
| wr_addr | input | 11 | Program-load byte address |
| wr_data | input | 8 | Program-load byte |
| pc | input | 64 | Selected fetch address |
| f_stat | output | 3 | Status: 1 ok, 2 halt, 3 address error, 4 invalid |
| f_icode | output | 4 | Operation code |
| f_ifun | output | 4 | Function code |
| f_rA | output | 4 | First register specifier |
| f_rB | output | 4 | Second register specifier |
| f_valC | output | 64 | Immediate constant |
| f_valP | output | 64 | Sequential next address |
| f_pred | output | 64 | Predicted next fetch address |
| f_inst_ok | output | 1 | Instruction code is valid |
| f_adr_err | output | 1 | Instruction bytes fall outside the store |
| f_halt | output | 1 | Halt instruction fetched |

## Verification
The hardest case to reach is an instruction that starts inside the store but runs past its top byte. Whether that raises an address error depends on the length decoded from the first byte, so the same bytes near the top can be legal or illegal depending on where fetch begins. The stimulus packs the last nine bytes so that a 9-byte jump starting at 2039 ends exactly on byte 2047. A 2-byte operation starts at 2045 and is also legal. The bytes at 2046 and 2047 decode as a jump and a call that would overrun the store. The bench also fetches well past the store and at the all-ones address to exercise next-address wrap.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    typedef enum logic [2:0] {
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } fstat_e;

    localparam logic [3:0] OP_HALT  = 4'h0;
    localparam logic [3:0] OP_NOP   = 4'h1;
    localparam logic [3:0] OP_CMOV  = 4'h2;
    localparam logic [3:0] OP_IRMOV = 4'h3;
    localparam logic [3:0] OP_RMMOV = 4'h4;
    localparam logic [3:0] OP_MRMOV = 4'h5;
    localparam logic [3:0] OP_ALU   = 4'h6;
    localparam logic [3:0] OP_JUMP  = 4'h7;
    localparam logic [3:0] OP_CALL  = 4'h8;
    localparam logic [3:0] OP_RET   = 4'h9;
    localparam logic [3:0] OP_PUSH  = 4'hA;
    localparam logic [3:0] OP_POP   = 4'hB;
    localparam logic [3:0] REG_NONE = 4'hF;

    function automatic logic [3:0] op_len(input logic [3:0] op);
        unique case (op)
            OP_CMOV, OP_ALU, OP_PUSH, OP_POP: op_len = 4'd2;
            OP_JUMP, OP_CALL:                 op_len = 4'd9;
            OP_IRMOV, OP_RMMOV, OP_MRMOV:     op_len = 4'd10;
            default:                          op_len = 4'd1;
        endcase
    endfunction

    function automatic logic op_has_regs(input logic [3:0] op);
        op_has_regs = (op inside {OP_CMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV,
                                  OP_ALU, OP_PUSH, OP_POP});
    endfunction

endpackage

// File: rtl/fetch_imem.sv
module fetch_imem #(
    parameter int MEM_BYTES = 2048,
    parameter int PC_W      = 64,
    parameter int WIN       = 10,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [PC_W-1:0]   pc,
    output logic [WIN*8-1:0]  win,
    output logic [WIN-1:0]    in_range
);
    localparam logic [PC_W-1:0] LIMIT = PC_W'(MEM_BYTES);

    logic [7:0] store [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst_n && wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    for (genvar k = 0; k < WIN; k++) begin : g_byte
        logic [PC_W-1:0] addr;
        assign addr        = pc + PC_W'(k);
        assign in_range[k] = (addr < LIMIT);
        assign win[k*8 +: 8] = in_range[k] ? store[addr[AW-1:0]] : 8'h00;
    end
endmodule

// File: rtl/fetch_split.sv
module fetch_split #(
    parameter int WIN = 10
) (
    input  logic [WIN*8-1:0] win,
    output logic [3:0]       op,
    output logic [3:0]       fn,
    output logic [3:0]       ra,
    output logic [3:0]       rb,
    output logic [63:0]      imm,
    output logic [3:0]       len
);
    import fetch_pkg::*;

    assign op  = win[7:4];
    assign fn  = win[3:0];
    assign len = op_len(op);

    always_comb begin
        ra = REG_NONE;
        rb = REG_NONE;
        if (op_has_regs(op)) begin
            ra = win[15:12];
            rb = win[11:8];
        end
    end

    always_comb begin
        unique case (op)
            OP_IRMOV, OP_RMMOV, OP_MRMOV: imm = win[79:16];
            OP_JUMP, OP_CALL:             imm = win[71:8];
            default:                      imm = 64'd0;
        endcase
    end
endmodule

// File: rtl/fetch_next.sv
module fetch_next #(
    parameter int MEM_BYTES = 2048,
    parameter int PC_W      = 64,
    parameter int WIN       = 10
) (
    input  logic [PC_W-1:0] pc,
    input  logic [WIN-1:0]  in_range,
    input  logic [3:0]      op,
    input  logic [3:0]      fn,
    input  logic [3:0]      ra,
    input  logic [3:0]      rb,
    input  logic [63:0]     imm,
    input  logic [3:0]      len,
    output logic [2:0]      stat,
    output logic [3:0]      o_op,
    output logic [3:0]      o_fn,
    output logic [3:0]      o_ra,
    output logic [3:0]      o_rb,
    output logic [63:0]     o_imm,
    output logic [PC_W-1:0] o_valp,
    output logic [PC_W-1:0] o_pred
);
    import fetch_pkg::*;

    localparam logic [PC_W-1:0] LIMIT = PC_W'(MEM_BYTES);

    logic   adr_bad;
    fstat_e st;

    assign adr_bad = !(pc < LIMIT) || !in_range[len - 4'd1];

    always_comb begin
        if (adr_bad)           st = ST_ADR;
        else if (op > OP_POP)  st = ST_INS;
        else if (op == OP_HALT) st = ST_HLT;
        else                   st = ST_AOK;
    end
    assign stat = st;

    always_comb begin
        if (adr_bad) begin
            o_op   = OP_NOP;
            o_fn   = 4'h0;
            o_ra   = REG_NONE;
            o_rb   = REG_NONE;
            o_imm  = 64'd0;
            o_valp = pc + PC_W'(1);
        end else begin
            o_op   = op;
            o_fn   = fn;
            o_ra   = ra;
            o_rb   = rb;
            o_imm  = imm;
            o_valp = pc + PC_W'(len);
        end
        o_pred = (o_op == OP_JUMP || o_op == OP_CALL) ? PC_W'(o_imm) : o_valp;
    end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit #(
    parameter int MEM_BYTES = 2048,
    parameter int PC_W      = 64,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [PC_W-1:0] pc,
    output logic [2:0]      f_stat,
    output logic [3:0]      f_icode,
    output logic [3:0]      f_ifun,
    output logic [3:0]      f_rA,
    output logic [3:0]      f_rB,
    output logic [63:0]     f_valC,
    output logic [PC_W-1:0] f_valP,
    output logic [PC_W-1:0] f_pred,
    output logic            f_inst_ok,
    output logic            f_adr_err,
    output logic            f_halt
);
    import fetch_pkg::*;

    localparam int WIN = 10;

    logic [WIN*8-1:0] win;
    logic [WIN-1:0]   in_range;
    logic [3:0]       op, fn, ra, rb, len;
    logic [63:0]      imm;

    fetch_imem #(.MEM_BYTES(MEM_BYTES), .PC_W(PC_W), .WIN(WIN)) u_imem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pc(pc), .win(win), .in_range(in_range)
    );

    fetch_split #(.WIN(WIN)) u_split (
        .win(win), .op(op), .fn(fn), .ra(ra), .rb(rb), .imm(imm), .len(len)
    );

    fetch_next #(.MEM_BYTES(MEM_BYTES), .PC_W(PC_W), .WIN(WIN)) u_next (
        .pc(pc), .in_range(in_range), .op(op), .fn(fn), .ra(ra), .rb(rb),
        .imm(imm), .len(len), .stat(f_stat), .o_op(f_icode), .o_fn(f_ifun),
        .o_ra(f_rA), .o_rb(f_rB), .o_imm(f_valC), .o_valp(f_valP),
        .o_pred(f_pred)
    );

    assign f_adr_err = (f_stat == ST_ADR);
    assign f_halt    = (f_stat == ST_HLT);
    assign f_inst_ok = (f_stat == ST_AOK) || (f_stat == ST_HLT);
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
    parameter int PC_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc,
    input logic [2:0]      f_stat,
    input logic [3:0]      f_icode,
    input logic [3:0]      f_rA,
    input logic [3:0]      f_rB,
    input logic [63:0]     f_valC,
    input logic [PC_W-1:0] f_valP,
    input logic [PC_W-1:0] f_pred,
    input logic            f_adr_err
);
    logic [PC_W-1:0] step;
    assign step = f_valP - pc;

    // R8
    adr_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_adr_err |-> (f_icode == 4'h1 && f_rA == 4'hF && f_rB == 4'hF
                       && f_valC == 64'd0 && step == PC_W'(1)));

    // R2
    valp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !f_adr_err |-> (step == PC_W'(1) || step == PC_W'(2)
                        || step == PC_W'(9) || step == PC_W'(10)));

    // R5
    pred_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_icode == 4'h7 || f_icode == 4'h8) |-> (f_pred == PC_W'(f_valC)));

    // R5
    pred_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_icode == 4'h7 || f_icode == 4'h8) |-> (f_pred == f_valP));

    // R3
    noreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_icode inside {4'h0, 4'h1, 4'h7, 4'h8, 4'h9} || f_icode > 4'hB)
            |-> (f_rA == 4'hF && f_rB == 4'hF));

    // R4
    noimm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_icode inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8}) |-> (f_valC == 64'd0));
endmodule

bind fetch_unit fetch_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc), .f_stat(f_stat), .f_icode(f_icode),
    .f_rA(f_rA), .f_rB(f_rB), .f_valC(f_valC), .f_valP(f_valP),
    .f_pred(f_pred), .f_adr_err(f_adr_err)
);

// File: tb/tb_fetch_unit.sv
module tb_fetch_unit;
    typedef struct packed {
        logic [63:0] pc;
        logic [3:0]  ic;
        logic [3:0]  fn;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [63:0] valc;
        logic [63:0] valp;
        logic [63:0] pred;
        logic [2:0]  st;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{64'd0,    4'h3, 4'h0, 4'hF, 4'h3, 64'h0123456789ABCDEF, 64'd10, 64'd10, 3'd1},
        '{64'd10,   4'h6, 4'h0, 4'h3, 4'h2, 64'd0,     64'd12,  64'd12,  3'd1},
        '{64'd12,   4'h7, 4'h0, 4'hF, 4'hF, 64'h40,    64'd21,  64'h40,  3'd1},
        '{64'd21,   4'h8, 4'h0, 4'hF, 4'hF, 64'h100,   64'd30,  64'h100, 3'd1},
        '{64'd30,   4'h9, 4'h0, 4'hF, 4'hF, 64'd0,     64'd31,  64'd31,  3'd1},
        '{64'd31,   4'hA, 4'h0, 4'h4, 4'hF, 64'd0,     64'd33,  64'd33,  3'd1},
        '{64'd33,   4'h1, 4'h0, 4'hF, 4'hF, 64'd0,     64'd34,  64'd34,  3'd1},
        '{64'd34,   4'h0, 4'h0, 4'hF, 4'hF, 64'd0,     64'd35,  64'd35,  3'd2},
        '{64'd35,   4'hC, 4'h0, 4'hF, 4'hF, 64'd0,     64'd36,  64'd36,  3'd4},
        '{64'd36,   4'h2, 4'h4, 4'h1, 4'h5, 64'd0,     64'd38,  64'd38,  3'd1},
        '{64'd38,   4'h5, 4'h0, 4'h6, 4'h1, 64'h18,    64'd48,  64'd48,  3'd1},
        '{64'd2039, 4'h7, 4'h0, 4'hF, 4'hF, 64'h8877665544332211, 64'd2048,
                                                       64'h8877665544332211, 3'd1},
        '{64'd2045, 4'h6, 4'h6, 4'h7, 4'h7, 64'd0,     64'd2047, 64'd2047, 3'd1},
        '{64'd2046, 4'h1, 4'h0, 4'hF, 4'hF, 64'd0,     64'd2047, 64'd2047, 3'd3},
        '{64'd2047, 4'h1, 4'h0, 4'hF, 4'hF, 64'd0,     64'd2048, 64'd2048, 3'd3},
        '{64'd4000, 4'h1, 4'h0, 4'hF, 4'hF, 64'd0,     64'd4001, 64'd4001, 3'd3},
        '{64'hFFFF_FFFF_FFFF_FFFF, 4'h1, 4'h0, 4'hF, 4'hF, 64'd0, 64'd0, 64'd0, 3'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [63:0] pc = '0;
    logic [2:0]  f_stat;
    logic [3:0]  f_icode, f_ifun, f_rA, f_rB;
    logic [63:0] f_valC, f_valP, f_pred;
    logic        f_inst_ok, f_adr_err, f_halt;

    int checks = 0;
    int fails  = 0;

    fetch_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pc(pc), .f_stat(f_stat), .f_icode(f_icode),
        .f_ifun(f_ifun), .f_rA(f_rA), .f_rB(f_rB), .f_valC(f_valC),
        .f_valP(f_valP), .f_pred(f_pred), .f_inst_ok(f_inst_ok),
        .f_adr_err(f_adr_err), .f_halt(f_halt)
    );

    always #4 clk = ~clk;

    task automatic put(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 11'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_q(input int a, input logic [63:0] q);
        for (int k = 0; k < 8; k++) put(a + k, q[k*8 +: 8]);
    endtask

    task automatic check_vec(input vec_t v);
        string tag;
        logic  eflag_a, eflag_h, eflag_ok;
        @(negedge clk);
        pc = v.pc;
        #1;
        if (v.st == 3'd3)      tag = "R8";
        else if (v.st == 3'd4) tag = "R6";
        else if (v.st == 3'd2) tag = "R7";
        else if (v.ic == 4'h7 || v.ic == 4'h8) tag = "R5";
        else if (v.valc != 0)  tag = "R4";
        else if (v.ra != 4'hF) tag = "R3";
        else                   tag = "R2";
        eflag_a  = (v.st == 3'd3);
        eflag_h  = (v.st == 3'd2);
        eflag_ok = (v.st == 3'd1) || (v.st == 3'd2);
        checks++;
        if (f_icode !== v.ic || f_ifun !== v.fn || f_rA !== v.ra || f_rB !== v.rb
            || f_valC !== v.valc || f_valP !== v.valp || f_pred !== v.pred
            || f_stat !== v.st || f_adr_err !== eflag_a || f_halt !== eflag_h
            || f_inst_ok !== eflag_ok) begin
            fails++;
            $display("FAIL %s pc=%0d: got ic=%h fn=%h ra=%h rb=%h c=%h p=%0d pr=%h st=%0d fl=%b%b%b exp ic=%h fn=%h ra=%h rb=%h c=%h p=%0d pr=%h st=%0d fl=%b%b%b (R1 R9)",
                     tag, v.pc, f_icode, f_ifun, f_rA, f_rB, f_valC, f_valP, f_pred,
                     f_stat, f_inst_ok, f_adr_err, f_halt, v.ic, v.fn, v.ra, v.rb,
                     v.valc, v.valp, v.pred, v.st, eflag_ok, eflag_a, eflag_h);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // program image
        put(0, 8'h30); put(1, 8'hF3); put_q(2, 64'h0123456789ABCDEF);
        put(10, 8'h60); put(11, 8'h32);
        put(12, 8'h70); put_q(13, 64'h40);
        put(21, 8'h80); put_q(22, 64'h100);
        put(30, 8'h90);
        put(31, 8'hA0); put(32, 8'h4F);
        put(33, 8'h10);
        put(34, 8'h00);
        put(35, 8'hC0);
        put(36, 8'h24); put(37, 8'h15);
        put(38, 8'h50); put(39, 8'h61); put_q(40, 64'h18);
        put(2039, 8'h70); put_q(2040, 64'h8877665544332211);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) check_vec(VECS[i]);

        // R10: write lands, then a write during reset is dropped
        put(200, 8'h10);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1; wr_addr = 11'd200; wr_data = 8'h00;
        @(negedge clk);
        wr_en = 1'b0;
        pc = 64'd200;
        #1;
        checks++;
        if (f_icode !== 4'h1) begin
            fails++;
            $display("FAIL R10 write in reset: icode=%h exp=1", f_icode);
        end
        @(negedge clk);
        rst_n = 1'b1;
        check_vec('{64'd200, 4'h1, 4'h0, 4'hF, 4'hF, 64'd0, 64'd201, 64'd201, 3'd1});

        // R10: normal write overwrites, byte becomes a halt
        put(200, 8'h00);
        check_vec('{64'd200, 4'h0, 4'h0, 4'hF, 4'hF, 64'd0, 64'd201, 64'd201, 3'd2});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule